// File: doc/BRIEF.md
# Shared I2C Pool RAM

This block holds a byte-wide RAM that several I2C channels share as transmit and receive staging space. A host register bus reaches the RAM with accesses one to four bytes wide. Each channel's command sequencer reaches it one byte at a time, and that byte is addressed by an index relative to the channel's own window. The block works out the start of every channel's window and publishes it. A compile-time parameter picks one of three address maps. In the paged map, the window start comes from a 3-bit page field and a 6-bit word-offset field per channel. In the two stride maps, it is the channel number times a fixed stride.

The host port and the channel port are both single-cycle request interfaces. Read data comes back from a register one cycle after the request. When the host and a channel ask in the same cycle, the host wins, and the channel keeps its request up until it is granted. Any byte whose address lands at or beyond the end of the pool is dropped on a write and returns zero on a read.

Top module: `i2c_pool_ram`

## Requirements
- R1: `host_size` gives the access width as size+1 bytes (0 means 1 byte, 3 means 4 bytes). A write touches only those bytes. On a read, the data lanes above the access width return zero.
- R2: Byte lane i of a host access (data bits 8i+7 down to 8i) maps to RAM address `host_addr`+i, which is little-endian lane order.
- R3: With `MODE` set to the paged map, the pool holds 2048 bytes, and the window start of channel c is page×256 + offset×4. Page is `page_sel[3c+2:3c]` and offset is `pool_off[6c+5:6c]`. The value appears on `win_base[12c+11:12c]`.
- R4: With `MODE` set to the 16-byte stride map, the pool holds 256 bytes and the window start of channel c is c×16. The page and offset inputs have no effect.
- R5: With `MODE` set to the 32-byte stride map, the pool holds 512 bytes and the window start of channel c is c×32.
- R6: A channel access addresses byte window start + `ch_idx`, so index 0 is the first byte of the window. A byte written from one port can be read back from the other.
- R7: `ch_gnt` is low in any cycle in which `host_req` is high. A channel request that is refused in that cycle is carried out in the first cycle with no host request, as long as `ch_req` stays high.
- R8: A byte whose address is at or beyond the pool size is not written, and it reads back as zero. Addresses do not wrap into the start of the pool, and this holds for both ports.
- R9: Read data and its valid flag appear one cycle after a host read, or after a granted channel read. `host_rvalid`/`ch_rvalid` are low otherwise, and the read data holds its last value.
- R10: After reset, both valid flags are low and both read-data outputs are zero. The RAM contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_req_i | input | 1 | Host access request |
| host_we_i | input | 1 | Host write (1) or read (0) |
| host_addr_i | input | 12 | Host byte address of lane 0 |
| host_size_i | input | 2 | Access width minus one |
| host_wdata_i | input | 32 | Host write data, little-endian lanes |
| host_rdata_o | output | 32 | Host read data |
| host_rvalid_o | output | 1 | Host read data valid |
| ch_req_i | input | 1 | Channel byte request |
| ch_we_i | input | 1 | Channel write (1) or read (0) |
| ch_id_i | input | log2(NUM_CH) | Requesting channel |
| ch_idx_i | input | 8 | Byte index within the channel window |
| ch_wdata_i | input | 8 | Channel write byte |
| ch_gnt_o | output | 1 | Channel request accepted this cycle |
| ch_rdata_o | output | 8 | Channel read byte |
| ch_rvalid_o | output | 1 | Channel read byte valid |
| page_sel_i | input | 3·NUM_CH | Per-channel page field (paged map) |
| pool_off_i | input | 6·NUM_CH | Per-channel word offset (paged map) |
| win_base_o | output | 12·NUM_CH | Per-channel window start address |

## Verification
The assertions assume three things about the inputs: `host_size` is always a defined 2-bit value, a channel requester holds `ch_req` and its operands steady until `ch_gnt` is seen, and reset is applied before the first request. The stimulus changes inputs only on the falling clock edge. It releases a refused channel request only after the grant, and it fills every RAM byte before reading it back. The page and offset fields are set before any channel access that depends on them.

// File: rtl/i2c_pool_pkg.sv
package i2c_pool_pkg;

    typedef enum logic [1:0] {
        MAP_PAGED    = 2'd0,
        MAP_STRIDE16 = 2'd1,
        MAP_STRIDE32 = 2'd2
    } map_mode_e;

    localparam int ADDR_W = 12;
    localparam int PAGE_W = 3;
    localparam int OFF_W  = 6;
    localparam int IDX_W  = 8;
    localparam int LANES  = 4;

    function automatic int pool_bytes(map_mode_e m);
        case (m)
            MAP_PAGED:    return 2048;
            MAP_STRIDE16: return 256;
            default:      return 512;
        endcase
    endfunction

    function automatic int win_stride(map_mode_e m);
        case (m)
            MAP_STRIDE16: return 16;
            default:      return 32;
        endcase
    endfunction

    typedef struct packed {
        logic [8*LANES-1:0] host_rdata;
        logic               host_rvalid;
        logic [7:0]         ch_rdata;
        logic               ch_rvalid;
    } rd_state_t;

endpackage

// File: rtl/pool_win_base.sv
module pool_win_base
    import i2c_pool_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_PAGED,
    parameter int        NUM_CH = 16
) (
    input  logic [NUM_CH*PAGE_W-1:0] page_sel_i,
    input  logic [NUM_CH*OFF_W-1:0]  pool_off_i,
    output logic [NUM_CH*ADDR_W-1:0] base_o
);

    localparam int PAGE_BYTES = 256;
    localparam int WORD_BYTES = 4;

    generate
        if (MODE == MAP_PAGED) begin : g_paged
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
                logic [ADDR_W-1:0] page_part;
                logic [ADDR_W-1:0] off_part;
                assign page_part = ADDR_W'(page_sel_i[c*PAGE_W +: PAGE_W]) * ADDR_W'(PAGE_BYTES);
                assign off_part  = ADDR_W'(pool_off_i[c*OFF_W +: OFF_W]) * ADDR_W'(WORD_BYTES);
                assign base_o[c*ADDR_W +: ADDR_W] = page_part + off_part;
            end
        end else begin : g_stride
            localparam int STRIDE = win_stride(MODE);
            logic unused_fields;
            assign unused_fields = ^{page_sel_i, pool_off_i};
            for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
                assign base_o[c*ADDR_W +: ADDR_W] = ADDR_W'(c * STRIDE);
            end
        end
    endgenerate

endmodule

// File: rtl/pool_arb.sv
module pool_arb
    import i2c_pool_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_PAGED,
    parameter int        NUM_CH = 16,
    localparam int       CH_W   = $clog2(NUM_CH),
    localparam int       MEM_AW = $clog2(pool_bytes(MODE))
) (
    input  logic                     host_req_i,
    input  logic                     ch_req_i,
    input  logic [CH_W-1:0]          ch_id_i,
    input  logic [IDX_W-1:0]         ch_idx_i,
    input  logic [NUM_CH*ADDR_W-1:0] base_i,
    output logic                     ch_gnt_o,
    output logic [MEM_AW-1:0]        ch_mem_addr_o,
    output logic                     ch_in_range_o
);

    localparam int POOL_BYTES = pool_bytes(MODE);

    logic [ADDR_W-1:0] base_sel;
    logic [ADDR_W:0]   full_addr;

    always_comb begin
        base_sel      = base_i[ch_id_i*ADDR_W +: ADDR_W];
        full_addr     = {1'b0, base_sel} + (ADDR_W+1)'(ch_idx_i);
        ch_in_range_o = full_addr < (ADDR_W+1)'(POOL_BYTES);
        ch_mem_addr_o = full_addr[MEM_AW-1:0];
        ch_gnt_o      = ch_req_i && !host_req_i;
    end

endmodule

// File: rtl/pool_mem.sv
module pool_mem
    import i2c_pool_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_PAGED,
    localparam int       MEM_AW = $clog2(pool_bytes(MODE))
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 host_req_i,
    input  logic                 host_we_i,
    input  logic [ADDR_W-1:0]    host_addr_i,
    input  logic [1:0]           host_size_i,
    input  logic [8*LANES-1:0]   host_wdata_i,
    output logic [8*LANES-1:0]   host_rdata_o,
    output logic                 host_rvalid_o,
    input  logic                 ch_gnt_i,
    input  logic                 ch_we_i,
    input  logic [MEM_AW-1:0]    ch_mem_addr_i,
    input  logic                 ch_in_range_i,
    input  logic [7:0]           ch_wdata_i,
    output logic [7:0]           ch_rdata_o,
    output logic                 ch_rvalid_o
);

    localparam int POOL_BYTES = pool_bytes(MODE);

    logic [7:0]      mem_q [POOL_BYTES];
    logic [ADDR_W:0] lane_addr [LANES];
    logic [LANES-1:0] lane_ok;
    logic [LANES-1:0] lane_we;
    logic            ch_wr;
    rd_state_t       rd_d, rd_q;

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_addr[i] = {1'b0, host_addr_i} + (ADDR_W+1)'(i);
            lane_ok[i]   = (2'(i) <= host_size_i) &&
                           (lane_addr[i] < (ADDR_W+1)'(POOL_BYTES));
            lane_we[i]   = host_req_i && host_we_i && lane_ok[i];
        end
        ch_wr = ch_gnt_i && ch_we_i && ch_in_range_i;
    end

    always_comb begin
        rd_d             = rd_q;
        rd_d.host_rvalid = 1'b0;
        rd_d.ch_rvalid   = 1'b0;
        if (host_req_i && !host_we_i) begin
            rd_d.host_rvalid = 1'b1;
            for (int i = 0; i < LANES; i++) begin
                rd_d.host_rdata[8*i +: 8] = lane_ok[i] ? mem_q[lane_addr[i][MEM_AW-1:0]] : 8'h00;
            end
        end
        if (ch_gnt_i && !ch_we_i) begin
            rd_d.ch_rvalid = 1'b1;
            rd_d.ch_rdata  = ch_in_range_i ? mem_q[ch_mem_addr_i] : 8'h00;
        end
    end

    always_ff @(posedge clk_i) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i]) begin
                mem_q[lane_addr[i][MEM_AW-1:0]] <= host_wdata_i[8*i +: 8];
            end
        end
        if (ch_wr) begin
            mem_q[ch_mem_addr_i] <= ch_wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata_o  = rd_q.host_rdata;
    assign host_rvalid_o = rd_q.host_rvalid;
    assign ch_rdata_o    = rd_q.ch_rdata;
    assign ch_rvalid_o   = rd_q.ch_rvalid;

    // R9
    host_rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_req_i && !host_we_i) |=> host_rvalid_o);

    // R9
    host_rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(host_req_i && !host_we_i) |=> (!host_rvalid_o && $stable(host_rdata_o)));

    // R7
    host_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ch_gnt_i |-> !host_req_i);

    // R8
    host_oob_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_req_i && !host_we_i && ({1'b0, host_addr_i} >= (ADDR_W+1)'(POOL_BYTES)))
        |=> (host_rdata_o == '0));

    // R1
    narrow_lane_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_req_i && !host_we_i && host_size_i == 2'd0) |=> (host_rdata_o[8*LANES-1:8] == '0));

    // R8
    ch_oob_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ch_gnt_i && !ch_we_i && !ch_in_range_i) |=> (ch_rdata_o == 8'h00));

    // R9
    ch_rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ch_gnt_i && !ch_we_i) |=> ch_rvalid_o);

endmodule

// File: rtl/i2c_pool_ram.sv
module i2c_pool_ram
    import i2c_pool_pkg::*;
#(
    parameter map_mode_e MODE   = MAP_PAGED,
    parameter int        NUM_CH = 16,
    localparam int       CH_W   = $clog2(NUM_CH)
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     host_req_i,
    input  logic                     host_we_i,
    input  logic [ADDR_W-1:0]        host_addr_i,
    input  logic [1:0]               host_size_i,
    input  logic [8*LANES-1:0]       host_wdata_i,
    output logic [8*LANES-1:0]       host_rdata_o,
    output logic                     host_rvalid_o,
    input  logic                     ch_req_i,
    input  logic                     ch_we_i,
    input  logic [CH_W-1:0]          ch_id_i,
    input  logic [IDX_W-1:0]         ch_idx_i,
    input  logic [7:0]               ch_wdata_i,
    output logic                     ch_gnt_o,
    output logic [7:0]               ch_rdata_o,
    output logic                     ch_rvalid_o,
    input  logic [NUM_CH*PAGE_W-1:0] page_sel_i,
    input  logic [NUM_CH*OFF_W-1:0]  pool_off_i,
    output logic [NUM_CH*ADDR_W-1:0] win_base_o
);

    localparam int MEM_AW = $clog2(pool_bytes(MODE));

    logic [MEM_AW-1:0] ch_mem_addr;
    logic              ch_in_range;

    pool_win_base #(.MODE(MODE), .NUM_CH(NUM_CH)) i_win_base (
        .page_sel_i (page_sel_i),
        .pool_off_i (pool_off_i),
        .base_o     (win_base_o)
    );

    pool_arb #(.MODE(MODE), .NUM_CH(NUM_CH)) i_arb (
        .host_req_i    (host_req_i),
        .ch_req_i      (ch_req_i),
        .ch_id_i       (ch_id_i),
        .ch_idx_i      (ch_idx_i),
        .base_i        (win_base_o),
        .ch_gnt_o      (ch_gnt_o),
        .ch_mem_addr_o (ch_mem_addr),
        .ch_in_range_o (ch_in_range)
    );

    pool_mem #(.MODE(MODE)) i_mem (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .host_req_i    (host_req_i),
        .host_we_i     (host_we_i),
        .host_addr_i   (host_addr_i),
        .host_size_i   (host_size_i),
        .host_wdata_i  (host_wdata_i),
        .host_rdata_o  (host_rdata_o),
        .host_rvalid_o (host_rvalid_o),
        .ch_gnt_i      (ch_gnt_o),
        .ch_we_i       (ch_we_i),
        .ch_mem_addr_i (ch_mem_addr),
        .ch_in_range_i (ch_in_range),
        .ch_wdata_i    (ch_wdata_i),
        .ch_rdata_o    (ch_rdata_o),
        .ch_rvalid_o   (ch_rvalid_o)
    );

endmodule

// File: tb/test_i2c_pool_ram.sv
module test_i2c_pool_ram;
    import i2c_pool_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_req = 0, host_we = 0;
    logic [11:0] host_addr = '0;
    logic [1:0]  host_size = '0;
    logic [31:0] host_wdata = '0;
    logic ch_req = 0, ch_we = 0;
    logic [3:0] ch_id = '0;
    logic [7:0] ch_idx = '0, ch_wdata = '0;
    logic [NCH*3-1:0]  page_sel = '0;
    logic [NCH*6-1:0]  pool_off = '0;

    logic [31:0] hrd_p, hrd_a, hrd_b;
    logic        hv_p, hv_a, hv_b;
    logic        gnt_p, gnt_a, gnt_b;
    logic [7:0]  crd_p, crd_a, crd_b;
    logic        cv_p, cv_a, cv_b;
    logic [NCH*12-1:0] wb_p, wb_a, wb_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_pool_ram #(.MODE(MAP_PAGED), .NUM_CH(NCH)) i_i2c_pool_ram (
        .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_size_i(host_size), .host_wdata_i(host_wdata),
        .host_rdata_o(hrd_p), .host_rvalid_o(hv_p), .ch_req_i(ch_req), .ch_we_i(ch_we),
        .ch_id_i(ch_id), .ch_idx_i(ch_idx), .ch_wdata_i(ch_wdata), .ch_gnt_o(gnt_p),
        .ch_rdata_o(crd_p), .ch_rvalid_o(cv_p), .page_sel_i(page_sel),
        .pool_off_i(pool_off), .win_base_o(wb_p));

    i2c_pool_ram #(.MODE(MAP_STRIDE16), .NUM_CH(NCH)) i_i2c_pool_ram_s16 (
        .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_size_i(host_size), .host_wdata_i(host_wdata),
        .host_rdata_o(hrd_a), .host_rvalid_o(hv_a), .ch_req_i(ch_req), .ch_we_i(ch_we),
        .ch_id_i(ch_id), .ch_idx_i(ch_idx), .ch_wdata_i(ch_wdata), .ch_gnt_o(gnt_a),
        .ch_rdata_o(crd_a), .ch_rvalid_o(cv_a), .page_sel_i(page_sel),
        .pool_off_i(pool_off), .win_base_o(wb_a));

    i2c_pool_ram #(.MODE(MAP_STRIDE32), .NUM_CH(NCH)) i_i2c_pool_ram_s32 (
        .clk_i(clk), .rst_ni(rst_n), .host_req_i(host_req), .host_we_i(host_we),
        .host_addr_i(host_addr), .host_size_i(host_size), .host_wdata_i(host_wdata),
        .host_rdata_o(hrd_b), .host_rvalid_o(hv_b), .ch_req_i(ch_req), .ch_we_i(ch_we),
        .ch_id_i(ch_id), .ch_idx_i(ch_idx), .ch_wdata_i(ch_wdata), .ch_gnt_o(gnt_b),
        .ch_rdata_o(crd_b), .ch_rvalid_o(cv_b), .page_sel_i(page_sel),
        .pool_off_i(pool_off), .win_base_o(wb_b));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [11:0] a, input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = a; host_size = s; host_wdata = d;
        @(negedge clk);
        host_req = 0; host_we = 0;
    endtask

    task automatic host_rd(input logic [11:0] a, input logic [1:0] s,
                           output logic [31:0] p, output logic [31:0] x, output logic [31:0] y);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = a; host_size = s;
        @(negedge clk);
        host_req = 0;
        chk("R9 host rvalid", {31'd0, hv_p}, 32'd1);
        p = hrd_p; x = hrd_a; y = hrd_b;
    endtask

    task automatic ch_op(input logic we, input logic [3:0] id, input logic [7:0] idx,
                         input logic [7:0] wd, output logic [7:0] p, output logic [7:0] x,
                         output logic [7:0] y);
        @(negedge clk);
        ch_req = 1; ch_we = we; ch_id = id; ch_idx = idx; ch_wdata = wd;
        #1 chk("R7 grant when host idle", {31'd0, gnt_p}, 32'd1);
        @(negedge clk);
        ch_req = 0; ch_we = 0;
        if (!we) chk("R9 ch rvalid", {31'd0, cv_p}, 32'd1);
        p = crd_p; x = crd_a; y = crd_b;
    endtask

    task automatic t_reset;
        chk("R10 host_rvalid", {31'd0, hv_p}, 32'd0);
        chk("R10 host_rdata", hrd_p, 32'd0);
        chk("R10 ch_rvalid", {31'd0, cv_p}, 32'd0);
        chk("R10 ch_rdata", {24'd0, crd_p}, 32'd0);
    endtask

    task automatic t_win_base;
        @(negedge clk);
        page_sel[2*3 +: 3] = 3'd5;  pool_off[2*6 +: 6] = 6'd9;
        page_sel[15*3 +: 3] = 3'd7; pool_off[15*6 +: 6] = 6'd63;
        #1;
        chk("R3 paged ch0", {20'd0, wb_p[0 +: 12]}, 32'h000);
        chk("R3 paged ch2", {20'd0, wb_p[2*12 +: 12]}, 32'h524);
        chk("R3 paged ch15", {20'd0, wb_p[15*12 +: 12]}, 32'h7FC);
        chk("R4 stride16 ch5", {20'd0, wb_a[5*12 +: 12]}, 32'h050);
        chk("R4 stride16 ch2 ignores page", {20'd0, wb_a[2*12 +: 12]}, 32'h020);
        chk("R5 stride32 ch5", {20'd0, wb_b[5*12 +: 12]}, 32'h0A0);
        chk("R5 stride32 ch15", {20'd0, wb_b[15*12 +: 12]}, 32'h1E0);
    endtask

    task automatic t_lanes;
        logic [31:0] p, x, y;
        host_wr(12'h040, 2'd3, 32'hDDCCBBAA);
        host_rd(12'h040, 2'd3, p, x, y);
        chk("R2 four-byte little-endian", p, 32'hDDCCBBAA);
        host_rd(12'h041, 2'd0, p, x, y);
        chk("R1 one-byte read upper lanes zero", p, 32'h000000BB);
        host_rd(12'h042, 2'd1, p, x, y);
        chk("R1 two-byte read", p, 32'h0000DDCC);
        host_wr(12'h041, 2'd0, 32'h11223344);
        host_rd(12'h040, 2'd3, p, x, y);
        chk("R1 one-byte write touches one lane", p, 32'hDDCC44AA);
        host_wr(12'h044, 2'd3, 32'h99999999);
        host_wr(12'h044, 2'd2, 32'hFF665544);
        host_rd(12'h044, 2'd3, p, x, y);
        chk("R1 three-byte write keeps lane 3", p, 32'h99665544);
        chk("R2 stride32 instance lanes", y, 32'h99665544);
    endtask

    task automatic t_channel;
        logic [31:0] p, x, y;
        logic [7:0] cp, ca, cb;
        ch_op(1'b1, 4'd2, 8'd3, 8'h5A, cp, ca, cb);
        host_rd(12'h527, 2'd0, p, x, y);
        chk("R6 paged ch write at base+idx", p, 32'h0000005A);
        host_rd(12'h023, 2'd0, p, x, y);
        chk("R6 stride16 ch write at base+idx", x, 32'h0000005A);
        host_rd(12'h043, 2'd0, p, x, y);
        chk("R6 stride32 ch write at base+idx", y, 32'h0000005A);
        host_wr(12'h524, 2'd0, 32'h00000077);
        ch_op(1'b0, 4'd2, 8'd0, 8'h00, cp, ca, cb);
        chk("R6 ch idx0 reads window start", {24'd0, cp}, 32'h77);
    endtask

    task automatic t_conflict;
        logic [31:0] p, x, y;
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = 12'h100; host_size = 2'd0; host_wdata = 32'h3C;
        ch_req = 1; ch_we = 0; ch_id = 4'd2; ch_idx = 8'd0;
        #1 chk("R7 no grant while host requests", {31'd0, gnt_p}, 32'd0);
        @(negedge clk);
        host_req = 0; host_we = 0;
        #1;
        chk("R7 refused read gives no rvalid", {31'd0, cv_p}, 32'd0);
        chk("R7 grant after host idle", {31'd0, gnt_p}, 32'd1);
        @(negedge clk);
        ch_req = 0;
        chk("R7 stalled read valid", {31'd0, cv_p}, 32'd1);
        chk("R7 stalled read data", {24'd0, crd_p}, 32'h77);
        host_rd(12'h100, 2'd0, p, x, y);
        chk("R7 host write done in conflict cycle", p, 32'h3C);
        chk("R8 stride16 write at 0x100 ignored", x, 32'h0);
    endtask

    task automatic t_oob;
        logic [31:0] p, x, y;
        logic [7:0] cp, ca, cb;
        host_wr(12'h000, 2'd3, 32'h04030201);
        host_wr(12'h7FE, 2'd3, 32'hA1B2C3D4);
        host_rd(12'h7FE, 2'd3, p, x, y);
        chk("R8 straddling read zero above pool", p, 32'h0000C3D4);
        host_rd(12'h000, 2'd3, p, x, y);
        chk("R8 no wrap into pool start", p, 32'h04030201);
        host_rd(12'h900, 2'd3, p, x, y);
        chk("R8 read beyond pool is zero", p, 32'h0);
        ch_op(1'b0, 4'd15, 8'd3, 8'h00, cp, ca, cb);
        chk("R6 paged last byte via channel", {24'd0, cp}, 32'hC3);
        ch_op(1'b1, 4'd15, 8'd4, 8'hEE, cp, ca, cb);
        ch_op(1'b0, 4'd15, 8'd4, 8'h00, cp, ca, cb);
        chk("R8 channel read beyond pool zero", {24'd0, cp}, 32'h0);
        host_rd(12'h000, 2'd3, p, x, y);
        chk("R8 channel write beyond pool ignored", p, 32'h04030201);
    endtask

    task automatic t_hold;
        @(negedge clk);
        @(negedge clk);
        chk("R9 rvalid low when idle", {31'd0, hv_p}, 32'd0);
        chk("R9 rdata holds when idle", hrd_p, 32'h04030201);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        t_reset();
        t_win_base();
        t_lanes();
        t_channel();
        t_conflict();
        t_oob();
        t_hold();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule